// File: doc/BRIEF.md
# Decision-Directed LMS Equalizer for 16-QAM

This block cleans up intersymbol interference on a 16-QAM baseband stream. It sits after down-conversion and after the timing stage has picked one sample per symbol. Each accepted complex sample enters a tapped delay line. The line feeds a complex FIR whose coefficients adapt by least mean squares. The filtered value is sliced to the nearest point of the square 16-QAM grid. That grid point is the reference for the adaptation, so no training sequence has to be sent. The equalized value, the decision and the error go on to a later phase-correction stage.

All samples use a signed fixed-point format with `FRAC` fraction bits, and coefficients use `CFRAC` fraction bits. The adaptation step is a power of two set by `step_shift`. A `freeze` input holds the coefficients, for example while the upstream loops settle. The active-low reset is asynchronous and is expected to be released in step with the clock.

Top module: `lms_qam_equalizer`

## Requirements
- R1: Reset clears the delay line and all outputs, and leaves only the middle coefficient (index NTAPS/2 = 16) at 1.0 with every other coefficient at 0. With the coefficients left alone, the equalized output for the n-th accepted sample therefore equals the input of accepted sample n-16, or zero when n is 16 or less.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high and low otherwise. eq, dec and err keep their values while out_valid is low.
- R3: The delay line moves by one position only when in_valid is high. Idle cycles between samples do not change which earlier sample lines up with each tap.
- R4: Per axis, the slicer compares the equalized value v with the thresholds -2.0, 0 and +2.0. It gives code 2'b00 (level -3) for v < -2.0, 2'b01 (level -1) for -2.0 <= v < 0, 2'b10 (level +1) for 0 <= v < 2.0, and 2'b11 (level +3) for v >= 2.0.
- R5: Per axis, err equals the decided level times 2^FRAC minus the equalized value. It is DW+1 bits wide, so it never wraps.
- R6: On a cycle with in_valid high and freeze low, every tap k takes w_k + ((e * conj(x_k)) >>> (2*FRAC - CFRAC + step_shift)), with each part clamped to CW bits. Here e is the error of that same cycle and x_k is the sample at tap k, the incoming sample being tap 0. The change shows from the next accepted sample on.
- R7: While freeze is high, or while in_valid is low, no coefficient changes.
- R8: The equalized value is the complex sum of w_k * x_k over all taps, arithmetically shifted right by CFRAC and clamped to the signed DW-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A symbol sample is present this cycle |
| in_i | input | DW | In-phase input sample, signed, FRAC fraction bits |
| in_q | input | DW | Quadrature input sample, signed, FRAC fraction bits |
| freeze | input | 1 | Hold all coefficients |
| step_shift | input | SW | Extra right shift that sets the adaptation step |
| out_valid | output | 1 | Results below belong to the sample accepted last cycle |
| eq_i | output | DW | Equalized in-phase value |
| eq_q | output | DW | Equalized quadrature value |
| dec_i | output | 2 | In-phase decision code (R4 coding) |
| dec_q | output | 2 | Quadrature decision code (R4 coding) |
| err_i | output | DW+1 | In-phase error, decided level minus equalized value |
| err_q | output | DW+1 | Quadrature error, decided level minus equalized value |

## Verification
The equalized value, the decision and the error for an accepted sample all come out of one register stage, so they are due on the clock edge after the in_valid cycle. The bench drives on falling edges and reads them at the next falling edge. A sample written into the line shows at the output on the 17th accepted sample, counting from the one that carries it, with idle cycles in between not counted. The bench tracks that count itself. A coefficient update made while a sample is accepted first shows in the result of the next accepted sample. The adaptation test therefore places a probe sample 16 accepted samples after the update and reads its result one edge later.

// File: rtl/eq_pkg.sv
package eq_pkg;

  // Per-axis decision code; bit 1 set means a non-negative level.
  typedef enum logic [1:0] {
    LVL_N3 = 2'b00,
    LVL_N1 = 2'b01,
    LVL_P1 = 2'b10,
    LVL_P3 = 2'b11
  } qam_lvl_e;

  function automatic int lvl_units(qam_lvl_e l);
    case (l)
      LVL_N3:  return -3;
      LVL_N1:  return -1;
      LVL_P1:  return 1;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/eq_tap_line.sv
module eq_tap_line #(
  parameter int NTAPS = 32,
  parameter int DW    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din_re,
  input  logic signed [DW-1:0] din_im,
  output logic signed [DW-1:0] win_re [NTAPS],
  output logic signed [DW-1:0] win_im [NTAPS]
);

  // Window = incoming sample at tap 0, stored history behind it.
  logic signed [DW-1:0] line_re [NTAPS-1];
  logic signed [DW-1:0] line_im [NTAPS-1];
  logic signed [DW-1:0] line_re_nxt [NTAPS-1];
  logic signed [DW-1:0] line_im_nxt [NTAPS-1];

  assign win_re[0] = din_re;
  assign win_im[0] = din_im;

  for (genvar k = 0; k < NTAPS-1; k++) begin : g_stage
    assign win_re[k+1] = line_re[k];
    assign win_im[k+1] = line_im[k];

    always_comb begin
      line_re_nxt[k] = line_re[k];
      line_im_nxt[k] = line_im[k];
      if (shift_en) begin
        line_re_nxt[k] = win_re[k];
        line_im_nxt[k] = win_im[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_re[k] <= '0;
        line_im[k] <= '0;
      end else begin
        line_re[k] <= line_re_nxt[k];
        line_im[k] <= line_im_nxt[k];
      end
    end
  end

endmodule

// File: rtl/eq_slicer.sv
module eq_slicer
  import eq_pkg::*;
#(
  parameter int DW   = 12,
  parameter int EW   = 13,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] y,
  output qam_lvl_e             code,
  output logic signed [EW-1:0] err
);

  localparam logic signed [DW-1:0] TH = DW'(2 << FRAC);

  always_comb begin
    if (y < -TH)      code = LVL_N3;
    else if (y < 0)   code = LVL_N1;
    else if (y < TH)  code = LVL_P1;
    else              code = LVL_P3;
    err = EW'(lvl_units(code) * (1 << FRAC)) - EW'(y);
  end

endmodule

// File: rtl/eq_coef_bank.sv
module eq_coef_bank #(
  parameter int NTAPS  = 32,
  parameter int DW     = 12,
  parameter int EW     = 13,
  parameter int CW     = 16,
  parameter int FRAC   = 8,
  parameter int CFRAC  = 14,
  parameter int SW     = 3,
  parameter int CENTRE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [SW-1:0]        step_shift,
  input  logic signed [EW-1:0] err_re,
  input  logic signed [EW-1:0] err_im,
  input  logic signed [DW-1:0] win_re [NTAPS],
  input  logic signed [DW-1:0] win_im [NTAPS],
  output logic signed [CW-1:0] coef_re [NTAPS],
  output logic signed [CW-1:0] coef_im [NTAPS]
);

  localparam int PW     = EW + DW + 1;
  localparam int SHIFT0 = 2*FRAC - CFRAC;
  localparam logic signed [PW:0]   CMAX = {{(PW-CW+2){1'b0}}, {(CW-1){1'b1}}};
  localparam logic signed [PW:0]   CMIN = ~CMAX;
  localparam logic signed [CW-1:0] ONE  = CW'(1 << CFRAC);

  function automatic logic signed [CW-1:0] clamp_c(input logic signed [PW:0] v);
    if (v > CMAX)      return CMAX[CW-1:0];
    else if (v < CMIN) return CMIN[CW-1:0];
    else               return v[CW-1:0];
  endfunction

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [CW-1:0] RST_VAL = (k == CENTRE) ? ONE : '0;

    logic signed [PW-1:0] g_re, g_im, d_re, d_im;
    logic signed [PW:0]   s_re, s_im;
    logic signed [CW-1:0] c_re_nxt, c_im_nxt;

    always_comb begin
      // e * conj(x)
      g_re = PW'(err_re) * PW'(win_re[k]) + PW'(err_im) * PW'(win_im[k]);
      g_im = PW'(err_im) * PW'(win_re[k]) - PW'(err_re) * PW'(win_im[k]);
      d_re = g_re >>> (SHIFT0 + int'(step_shift));
      d_im = g_im >>> (SHIFT0 + int'(step_shift));
      s_re = (PW+1)'(coef_re[k]) + (PW+1)'(d_re);
      s_im = (PW+1)'(coef_im[k]) + (PW+1)'(d_im);
      c_re_nxt = coef_re[k];
      c_im_nxt = coef_im[k];
      if (upd_en) begin
        c_re_nxt = clamp_c(s_re);
        c_im_nxt = clamp_c(s_im);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_re[k] <= RST_VAL;
        coef_im[k] <= '0;
      end else begin
        coef_re[k] <= c_re_nxt;
        coef_im[k] <= c_im_nxt;
      end
    end
  end

endmodule

// File: rtl/lms_qam_equalizer.sv
module lms_qam_equalizer
  import eq_pkg::*;
#(
  parameter int NTAPS = 32,
  parameter int DW    = 12,
  parameter int FRAC  = 8,
  parameter int CW    = 16,
  parameter int CFRAC = 14,
  parameter int SW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 freeze,
  input  logic [SW-1:0]        step_shift,
  output logic                 out_valid,
  output logic signed [DW-1:0] eq_i,
  output logic signed [DW-1:0] eq_q,
  output logic [1:0]           dec_i,
  output logic [1:0]           dec_q,
  output logic signed [DW:0]   err_i,
  output logic signed [DW:0]   err_q
);

  localparam int CENTRE = NTAPS / 2;
  localparam int EW     = DW + 1;
  localparam int MW     = CW + DW + 1;
  localparam int ACW    = MW + $clog2(NTAPS);
  localparam logic signed [ACW-1:0] YMAX = {{(ACW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACW-1:0] YMIN = ~YMAX;

  logic signed [DW-1:0]  win_re  [NTAPS];
  logic signed [DW-1:0]  win_im  [NTAPS];
  logic signed [CW-1:0]  coef_re [NTAPS];
  logic signed [CW-1:0]  coef_im [NTAPS];
  logic signed [ACW-1:0] acc_re, acc_im, sh_re, sh_im;
  logic signed [DW-1:0]  y_re, y_im;
  qam_lvl_e              code_i, code_q;
  logic signed [EW-1:0]  e_re, e_im;
  logic                  upd_en;

  logic                  out_valid_nxt;
  logic signed [DW-1:0]  eq_i_nxt, eq_q_nxt;
  logic [1:0]            dec_i_nxt, dec_q_nxt;
  logic signed [EW-1:0]  err_i_nxt, err_q_nxt;

  function automatic logic signed [DW-1:0] clamp_y(input logic signed [ACW-1:0] v);
    if (v > YMAX)      return YMAX[DW-1:0];
    else if (v < YMIN) return YMIN[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  eq_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_valid),
    .din_re   (in_i),
    .din_im   (in_q),
    .win_re   (win_re),
    .win_im   (win_im)
  );

  // Complex FIR over the window including the incoming sample.
  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc_re = acc_re + ACW'(MW'(coef_re[k]) * MW'(win_re[k]))
                      - ACW'(MW'(coef_im[k]) * MW'(win_im[k]));
      acc_im = acc_im + ACW'(MW'(coef_re[k]) * MW'(win_im[k]))
                      + ACW'(MW'(coef_im[k]) * MW'(win_re[k]));
    end
    sh_re = acc_re >>> CFRAC;
    sh_im = acc_im >>> CFRAC;
    y_re  = clamp_y(sh_re);
    y_im  = clamp_y(sh_im);
  end

  eq_slicer #(.DW(DW), .EW(EW), .FRAC(FRAC)) u_slice_i (
    .y (y_re), .code (code_i), .err (e_re)
  );

  eq_slicer #(.DW(DW), .EW(EW), .FRAC(FRAC)) u_slice_q (
    .y (y_im), .code (code_q), .err (e_im)
  );

  assign upd_en = in_valid & ~freeze;

  eq_coef_bank #(
    .NTAPS (NTAPS), .DW (DW), .EW (EW), .CW (CW),
    .FRAC (FRAC), .CFRAC (CFRAC), .SW (SW), .CENTRE (CENTRE)
  ) u_coef (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .step_shift (step_shift),
    .err_re     (e_re),
    .err_im     (e_im),
    .win_re     (win_re),
    .win_im     (win_im),
    .coef_re    (coef_re),
    .coef_im    (coef_im)
  );

  always_comb begin
    out_valid_nxt = in_valid;
    eq_i_nxt  = eq_i;
    eq_q_nxt  = eq_q;
    dec_i_nxt = dec_i;
    dec_q_nxt = dec_q;
    err_i_nxt = err_i;
    err_q_nxt = err_q;
    if (in_valid) begin
      eq_i_nxt  = y_re;
      eq_q_nxt  = y_im;
      dec_i_nxt = code_i;
      dec_q_nxt = code_q;
      err_i_nxt = e_re;
      err_q_nxt = e_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      eq_i      <= '0;
      eq_q      <= '0;
      dec_i     <= '0;
      dec_q     <= '0;
      err_i     <= '0;
      err_q     <= '0;
    end else begin
      out_valid <= out_valid_nxt;
      eq_i      <= eq_i_nxt;
      eq_q      <= eq_q_nxt;
      dec_i     <= dec_i_nxt;
      dec_q     <= dec_q_nxt;
      err_i     <= err_i_nxt;
      err_q     <= err_q_nxt;
    end
  end

endmodule

// File: rtl/eq_checker.sv
module eq_checker
  import eq_pkg::*;
#(
  parameter int DW   = 12,
  parameter int EW   = 13,
  parameter int CW   = 16,
  parameter int FRAC = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 freeze,
  input logic                 out_valid,
  input logic signed [DW-1:0] eq_i,
  input logic signed [DW-1:0] eq_q,
  input logic [1:0]           dec_i,
  input logic [1:0]           dec_q,
  input logic signed [EW-1:0] err_i,
  input logic signed [EW-1:0] err_q,
  input logic signed [CW-1:0] cen_re,
  input logic signed [CW-1:0] cen_im
);

  localparam logic signed [DW-1:0] TH = DW'(2 << FRAC);

  function automatic logic signed [EW-1:0] lvl_val(input logic [1:0] d);
    return EW'(lvl_units(qam_lvl_e'(d)) * (1 << FRAC));
  endfunction

  assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(eq_i) && $stable(eq_q) && $stable(dec_i) &&
                   $stable(dec_q) && $stable(err_i) && $stable(err_q)));

  assert_slice_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((eq_i >= TH) == (dec_i == 2'b11)) &&
                   ((eq_i < -TH) == (dec_i == 2'b00)) &&
                   ((eq_i >= 0) == dec_i[1])));

  assert_slice_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((eq_q >= TH) == (dec_q == 2'b11)) &&
                   ((eq_q < -TH) == (dec_q == 2'b00)) &&
                   ((eq_q >= 0) == dec_q[1])));

  assert_err_i_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (err_i == lvl_val(dec_i) - EW'(eq_i)));

  assert_err_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (err_q == lvl_val(dec_q) - EW'(eq_q)));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze || !in_valid) |=> ($stable(cen_re) && $stable(cen_im)));

endmodule

bind lms_qam_equalizer eq_checker #(
  .DW (DW), .EW (EW), .CW (CW), .FRAC (FRAC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .freeze    (freeze),
  .out_valid (out_valid),
  .eq_i      (eq_i),
  .eq_q      (eq_q),
  .dec_i     (dec_i),
  .dec_q     (dec_q),
  .err_i     (err_i),
  .err_q     (err_q),
  .cen_re    (coef_re[CENTRE]),
  .cen_im    (coef_im[CENTRE])
);

// File: tb/lms_qam_equalizer_bench.sv
module lms_qam_equalizer_bench;

  localparam int DW = 12;
  localparam int SW = 3;

  typedef struct packed {
    int xi; int xq; int di; int dq; int ei; int eq;
  } vec_t;

  // input sample, expected decision codes and errors when passed at unity gain
  localparam vec_t VEC [8] = '{
    '{0,     0,     2, 2,  256,   256},
    '{512,   -512,  3, 1,  256,   256},
    '{511,   -513,  2, 0,  -255,  -255},
    '{-1,    1,     1, 2,  -255,  255},
    '{768,   -768,  3, 0,  0,     0},
    '{2047,  -2048, 3, 0,  -1279, 1280},
    '{-2048, 2047,  0, 3,  1280,  -1279},
    '{100,   -300,  2, 1,  156,   44}
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic signed [DW-1:0] in_i, in_q;
  logic                 freeze;
  logic [SW-1:0]        step_shift;
  logic                 out_valid;
  logic signed [DW-1:0] eq_i, eq_q;
  logic [1:0]           dec_i, dec_q;
  logic signed [DW:0]   err_i, err_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lms_qam_equalizer u_lms_qam_equalizer (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_i (in_i), .in_q (in_q),
    .freeze (freeze), .step_shift (step_shift), .out_valid (out_valid),
    .eq_i (eq_i), .eq_q (eq_q), .dec_i (dec_i), .dec_q (dec_q),
    .err_i (err_i), .err_q (err_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int yi, input int yq,
                         input int di, input int dq, input int ei, input int eq);
    chk({tag, " out_valid"}, int'(out_valid), 1);
    chk({tag, " eq_i"},  int'(eq_i),  yi);
    chk({tag, " eq_q"},  int'(eq_q),  yq);
    chk({tag, " dec_i"}, int'(dec_i), di);
    chk({tag, " dec_q"}, int'(dec_q), dq);
    chk({tag, " err_i"}, int'(err_i), ei);
    chk({tag, " err_q"}, int'(err_q), eq);
  endtask

  // Called at a falling edge; drives, then returns at the next falling edge.
  task automatic cyc(input logic v, input int xi, input int xq, input logic frz);
    in_valid = v;
    in_i     = DW'(xi);
    in_q     = DW'(xq);
    freeze   = frz;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(1'b0, 0, 0, 1'b1);
    cyc(1'b0, 0, 0, 1'b1);
    rst_n = 1'b1;
    cyc(1'b0, 0, 0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    freeze = 1'b1; step_shift = 3'd2;
    @(negedge clk);
    cyc(1'b0, 0, 0, 1'b1);
    // R1: reset state
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset eq_i", int'(eq_i), 0);
    chk("R1 reset err_q", int'(err_q), 0);
    rst_n = 1'b1;
    cyc(1'b0, 0, 0, 1'b1);
    chk("R2 idle out_valid", int'(out_valid), 0);

    // Table walk, frozen unity centre tap (R1 R3 R4 R5 R7 R8), with idle gaps (R2 R3)
    for (int n = 1; n <= 24; n++) begin
      vec_t src, exp;
      src = (n <= 8) ? VEC[n-1] : '{0, 0, 2, 2, 256, 256};
      exp = (n >= 17) ? VEC[n-17] : '{0, 0, 2, 2, 256, 256};
      cyc(1'b1, src.xi, src.xq, 1'b1);
      chk_out($sformatf("R1 R4 R5 R7 vec n=%0d", n), exp.xi, exp.xq, exp.di, exp.dq, exp.ei, exp.eq);
      for (int g = 0; g < n % 3; g++) begin
        cyc(1'b0, 7, -7, 1'b0);
        chk($sformatf("R2 gap valid n=%0d", n), int'(out_valid), 0);
        chk($sformatf("R2 R3 gap hold n=%0d", n), int'(eq_i), exp.xi);
      end
    end

    // Adaptation on imaginary sample (R6): w16 -> 0.8125 - 0.375j
    do_reset();
    cyc(1'b1, 0, 384, 1'b1);
    for (int n = 2; n <= 16; n++) cyc(1'b1, 0, 0, 1'b1);
    step_shift = 3'd2;
    cyc(1'b1, 0, 0, 1'b0);
    chk_out("R6 update cycle", 0, 384, 2, 2, 256, -128);
    cyc(1'b1, 256, 256, 1'b1);
    for (int n = 19; n <= 33; n++) cyc(1'b1, 0, 0, 1'b1);
    cyc(1'b0, 0, 0, 1'b1);
    cyc(1'b1, 0, 0, 1'b1);
    chk_out("R6 R8 probe", 304, 112, 2, 2, -48, 144);

    // Mid-run reset restores unity centre tap (R1)
    do_reset();
    cyc(1'b1, -384, 640, 1'b1);
    for (int n = 2; n <= 16; n++) cyc(1'b1, 0, 0, 1'b1);
    cyc(1'b1, 0, 0, 1'b1);
    chk_out("R1 coef reset", -384, 640, 1, 3, 128, 128);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule